// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block turns one 128-bit AES ciphertext block back into plaintext under a 128-bit cipher key. A host places the ciphertext and the key on their buses and pulses `start` while the block is idle. The block captures both and expands the key into all eleven round keys, one per clock. It then removes the cipher rounds in reverse order: it adds the last round key first and walks the stored schedule down to the original key. Each inverse step takes its own clock cycle and uses one shared datapath, so the block stays small.

A seven-state controller runs the sequence. One state produces each round key. One state applies the opening key addition. Three states share the round work: a fused inverse row shift and inverse byte substitution, a round-key addition, and the inverse column mix. A last state presents the result. The column mix is not used on the final pass, which adds the original key. The plaintext is shown together with a one-cycle `done` pulse and then holds until the next result.

Top module: `aes128_decrypt`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are 0 and `pt_o` is all zeros until the first result appears.
- R2: With key 000102030405060708090a0b0c0d0e0f and ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a, the block returns 00112233445566778899aabbccddeeff. Byte 0 of every bus is bits 127:120, and the state is filled column by column.
- R3: For any key and plaintext, decrypting the AES-128 encryption of that plaintext under that key returns the plaintext.
- R4: `done` rises exactly 41 clock cycles after the clock edge at which `start` is accepted.
- R5: `done` is high for exactly one cycle per accepted `start`.
- R6: `busy` is high from the cycle after acceptance until `done` rises, and is low in the cycle where `done` is high.
- R7: `start` is accepted only while `busy` is low. A `start` seen while busy, together with the ciphertext and key it carries, has no effect on the current result or its timing.
- R8: `pt_o` changes only in a cycle where `done` is high and otherwise holds its last value.
- R9: The ten inverse rounds use the round keys in the order 10 down to 0. The inverse column mix uses the matrix {0e,0b,0d,09} over GF(2^8) modulo 0x11B and is not applied in the pass that adds key 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to decrypt; accepted only when `busy` is low |
| ct_i | input | 128 | Ciphertext block, captured on acceptance |
| key_i | input | 128 | Cipher key, captured on acceptance |
| busy | output | 1 | High while a block is being processed |
| done | output | 1 | One-cycle pulse marking a new plaintext |
| pt_o | output | 128 | Recovered plaintext, held between pulses |

## Verification
The assertions assume that `ct_i` and `key_i` matter only in the cycle when `start` is accepted. They also assume reset is held for at least one rising edge before any request. The bench changes inputs only on the falling clock edge and issues a tracked request only after its model reports the block idle. When it tests R7, it deliberately pulses `start` with different data in the middle of a run. It pushes no expected result for that pulse, so any acceptance of it would show up as a wrong value or wrong timing.

// File: rtl/aes_dec_pkg.sv
// Package: shared sizes, controller state type and GF(2^8) arithmetic for
// the AES-128 decryptor. Assumes the AES field polynomial 0x11B.
package aes_dec_pkg;
    localparam int BYTE_W = 8;
    localparam int ROWS   = 4;
    localparam int NBYTE  = 16;
    localparam int BLK_W  = NBYTE * BYTE_W;
    localparam int WORD_W = ROWS * BYTE_W;
    localparam int NROUND = 10;
    localparam int RND_W  = $clog2(NROUND + 1);
    localparam int NKEY   = NROUND + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXPAND, ST_ADD_FIRST, ST_SHSUB, ST_ADDKEY, ST_MIX, ST_FINISH
    } dec_state_t;

    // multiply by x modulo the field polynomial
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general field multiply, shift-and-add
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc, sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (0 maps to 0)
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] res, base;
        res  = 8'h01;
        base = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) res = gmul(res, base);
            base = gmul(base, base);
        end
        return res;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // forward substitution: inverse then affine map
    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] v;
        v = ginv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // inverse substitution: inverse affine map then field inverse
    function automatic logic [7:0] inv_sbox(input logic [7:0] a);
        return ginv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

    // coefficient of the inverse mix matrix at circulant distance d
    function automatic logic [7:0] imix_coef(input int d);
        case (d)
            0:       return 8'h0e;
            1:       return 8'h0b;
            2:       return 8'h0d;
            default: return 8'h09;
        endcase
    endfunction
endpackage

// File: rtl/aes_dec_keyexp.sv
// Key step: derives the next AES-128 round key from the previous one and the
// round constant. Purely combinational; the caller sequences the constants.
module aes_dec_keyexp
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0]  prev_key,
    input  logic [BYTE_W-1:0] rcon,
    output logic [BLK_W-1:0]  next_key
);
    logic [WORD_W-1:0] last_w, mixed_w;
    logic [WORD_W-1:0] w0, w1, w2, w3;

    // rotate, substitute and fold in the constant, then chain the words
    always_comb begin
        last_w  = prev_key[WORD_W-1:0];
        mixed_w = {sbox(last_w[23:16]), sbox(last_w[15:8]),
                   sbox(last_w[7:0]),   sbox(last_w[31:24])}
                  ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
        w0 = prev_key[4*WORD_W-1:3*WORD_W] ^ mixed_w;
        w1 = prev_key[3*WORD_W-1:2*WORD_W] ^ w0;
        w2 = prev_key[2*WORD_W-1:WORD_W]   ^ w1;
        w3 = last_w ^ w2;
        next_key = {w0, w1, w2, w3};
    end
endmodule

// File: rtl/aes_dec_invshsub.sv
// Fused inverse row shift and inverse substitution. Row r of the
// column-major state moves right by r bytes; each byte is then substituted.
module aes_dec_invshsub
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout
);
    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        localparam int COL = k / ROWS;
        localparam int ROW = k % ROWS;
        localparam int SRC = ROWS * ((COL - ROW + ROWS) % ROWS) + ROW;
        // pick the source byte and substitute it
        assign dout[BLK_W-1-BYTE_W*k -: BYTE_W] =
            inv_sbox(din[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
    end
endmodule

// File: rtl/aes_dec_invmix.sv
// Inverse column mix: each 4-byte column times the circulant matrix
// {0e,0b,0d,09} over GF(2^8).
module aes_dec_invmix
    import aes_dec_pkg::*;
(
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout
);
    for (genvar c = 0; c < ROWS; c++) begin : g_col
        // one matrix-vector product per column
        always_comb begin
            logic [BYTE_W-1:0] acc;
            for (int j = 0; j < ROWS; j++) begin
                acc = '0;
                for (int i = 0; i < ROWS; i++)
                    acc = acc ^ gmul(din[BLK_W-1-BYTE_W*(ROWS*c+i) -: BYTE_W],
                                     imix_coef((i - j + ROWS) % ROWS));
                dout[BLK_W-1-BYTE_W*(ROWS*c+j) -: BYTE_W] = acc;
            end
        end
    end
endmodule

// File: rtl/aes128_decrypt.sv
// AES-128 decryptor top. A seven-state controller expands the key into a
// stored schedule, then runs the inverse rounds one stage per clock, reading
// keys from 10 down to 0. Assumes ct_i and key_i are valid when start is
// accepted (busy low); they are ignored at all other times.
module aes128_decrypt
    import aes_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  ct_i,
    input  logic [BLK_W-1:0]  key_i,
    output logic              busy,
    output logic              done,
    output logic [BLK_W-1:0]  pt_o
);
    dec_state_t        state;
    logic [RND_W-1:0]  rnd;
    logic [BLK_W-1:0]  ct_q, st_q, kcur, key_nx, shsub_out, mix_out, pt_q;
    logic [BYTE_W-1:0] rcon_q;
    logic              done_q;
    logic [BLK_W-1:0]  rk [NKEY];

    aes_dec_keyexp   u_kexp  (.prev_key(kcur), .rcon(rcon_q), .next_key(key_nx));
    aes_dec_invshsub u_shsub (.din(st_q), .dout(shsub_out));
    aes_dec_invmix   u_mix   (.din(st_q), .dout(mix_out));

    // round-key storage, written at acceptance and during expansion
    always_ff @(posedge clk) begin
        if (state == ST_IDLE && start) rk[0]   <= key_i;
        else if (state == ST_EXPAND)   rk[rnd] <= key_nx;
    end

    // controller and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rnd    <= '0;
            ct_q   <= '0;
            st_q   <= '0;
            kcur   <= '0;
            rcon_q <= 8'h01;
            pt_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    ct_q   <= ct_i;
                    kcur   <= key_i;
                    rcon_q <= 8'h01;
                    rnd    <= RND_W'(1);
                    state  <= ST_EXPAND;
                end
                ST_EXPAND: begin
                    kcur   <= key_nx;
                    rcon_q <= xtime(rcon_q);
                    if (rnd == RND_W'(NROUND)) state <= ST_ADD_FIRST;
                    else                       rnd   <= rnd + RND_W'(1);
                end
                ST_ADD_FIRST: begin
                    st_q  <= ct_q ^ rk[NROUND];
                    state <= ST_SHSUB;
                end
                ST_SHSUB: begin
                    st_q  <= shsub_out;
                    rnd   <= rnd - RND_W'(1);
                    state <= ST_ADDKEY;
                end
                ST_ADDKEY: begin
                    st_q  <= st_q ^ rk[rnd];
                    state <= (rnd == '0) ? ST_FINISH : ST_MIX;
                end
                ST_MIX: begin
                    st_q  <= mix_out;
                    state <= ST_SHSUB;
                end
                ST_FINISH: begin
                    pt_q   <= st_q;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = done_q;
    assign pt_o = pt_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state == ST_IDLE));
    // R8
    pt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(pt_q));
    // R7
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(ct_q));
    // R9
    mix_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIX) |-> (rnd != '0));
    // R9
    first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD_FIRST) |=> (state == ST_SHSUB && rnd == RND_W'(NROUND)));
endmodule

// File: tb/aes128_decrypt_test.sv
module aes128_decrypt_test;
    localparam int LAT = 41;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] ct = '0, key = '0;
    logic         busy, done;
    logic [127:0] pt;

    int n_chk = 0, n_err = 0;

    aes128_decrypt uut (.clk(clk), .rst_n(rst_n), .start(start), .ct_i(ct),
                        .key_i(key), .busy(busy), .done(done), .pt_o(pt));

    always #4 clk = ~clk;

    // ---------------- encryption model built from field tables ----------------
    logic [7:0] sb [256];

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    task automatic build_sbox();
        logic [7:0] p, q;
        p = 8'h01; q = 8'h01;
        repeat (255) begin
            p = p ^ xt(p);
            q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
        end
        sb[0] = 8'h63;
    endtask

    function automatic logic [127:0] key_step(input logic [127:0] k, input logic [7:0] rc);
        logic [31:0] t, w [4];
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        t = {sb[w[3][23:16]] ^ rc, sb[w[3][15:8]], sb[w[3][7:0]], sb[w[3][31:24]]};
        w[0] = w[0] ^ t;
        for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
        return {w[0], w[1], w[2], w[3]};
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] p, input logic [127:0] k0);
        logic [127:0] k, s, t;
        logic [7:0]   rc, a0, a1, a2, a3;
        k = k0; s = p ^ k0; rc = 8'h01;
        for (int r = 1; r <= 10; r++) begin
            k = key_step(k, rc); rc = xt(rc);
            for (int i = 0; i < 16; i++) begin
                int c, rw, src;
                c = i / 4; rw = i % 4; src = 4 * ((c + rw) % 4) + rw;
                t[127-8*i -: 8] = sb[s[127-8*src -: 8]];
            end
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = t[127-32*c -: 8];    a1 = t[119-32*c -: 8];
                    a2 = t[111-32*c -: 8];    a3 = t[103-32*c -: 8];
                    s[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end else s = t;
            s = s ^ k;
        end
        return s;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle model: accepted request -> done LAT edges later with queued plaintext
    logic [127:0] exp_q [$];
    int           m_cnt = 0;
    logic         m_done = 1'b0;
    logic [127:0] m_pt = '0, m_pend = '0;
    bit           run_chk = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_pt = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt == 0) begin
                if (start) begin
                    m_cnt = LAT;
                    m_pend = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin m_done = 1'b1; m_pt = m_pend; end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            chk("R4 R5 done", {127'd0, done}, {127'd0, m_done});
            chk("R6 busy", {127'd0, busy}, {127'd0, (m_cnt > 0)});
            chk("R8 plaintext", pt, m_pt);
        end
    end

    // request one decryption, wait for it, check result and latency
    task automatic run_one(input string req, input logic [127:0] c_in,
                           input logic [127:0] k_in, input logic [127:0] p_exp);
        int cyc;
        while (m_cnt != 0) @(negedge clk);
        ct = c_in; key = k_in; exp_q.push_back(p_exp); start = 1'b1;
        @(negedge clk);
        start = 1'b0; ct = '0; key = '0;
        cyc = 0;
        while (!done) begin @(negedge clk); cyc++; end
        chk(req, pt, p_exp);
        chk("R4 latency", 128'(cyc), 128'(LAT));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [127:0] fk, fc, fp, p, k, c;
        build_sbox();
        fk = 128'h000102030405060708090a0b0c0d0e0f;
        fc = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        fp = 128'h00112233445566778899aabbccddeeff;

        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1 busy in reset", {127'd0, busy}, '0);
        chk("R1 done in reset", {127'd0, done}, '0);
        chk("R1 pt in reset", pt, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", {127'd0, busy}, '0);
        chk("R1 pt after reset", pt, '0);
        run_chk = 1'b1;

        // model sanity against the published vector
        chk("R3 model", encrypt(fp, fk), fc);

        // R2: published vector; R9 key order and last-pass mix skip follow from it
        run_one("R2 vector", fc, fk, fp);

        // R8: result holds after the pulse
        repeat (5) @(negedge clk);
        chk("R8 hold", pt, fp);

        // R3: corner patterns and random round trips, back to back
        run_one("R3 zero", encrypt('0, '0), '0, '0);
        run_one("R3 ones", encrypt('1, '1), '1, '1);
        for (int n = 0; n < 20; n++) begin
            p = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            run_one("R3 round trip", encrypt(p, k), k, p);
        end

        // R7: start pulses with other data mid-run are ignored
        p = 128'hdeadbeef_01234567_89abcdef_0f1e2d3c;
        k = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
        c = encrypt(p, k);
        while (m_cnt != 0) @(negedge clk);
        ct = c; key = k; exp_q.push_back(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        ct = ~c; key = ~k; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        ct = fc; key = fk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R7 ignored start", pt, p);
        @(negedge clk);
        chk("R5 single pulse", {127'd0, done}, '0);
        chk("R6 idle after", {127'd0, busy}, '0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule